// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the fetch address for a program store of 512 eight-bit words. A 9-bit program counter advances by one on every instruction cycle unless a control-transfer command is presented with the cycle strobe. In that case the counter loads one of three targets: a full 9-bit jump target, a target inside the current 64-word page, or a subroutine entry point.

The store is viewed as eight pages of 64 words, so the upper three address bits name the page. A subroutine call saves the address after the call in a two-entry save stack. A return restores the most recent saved address. Instruction decoding and the program store itself live outside this block. The decoder drives the command code and target each cycle, and the store reads `fetch_addr_o`.

Top module: `prog_addr_seq`

## Requirements
- R1: When `rst_i` is high at a clock edge, the program counter and both save-stack entries become 0.
- R2: When `step_i` is low, the program counter and both save-stack entries keep their values, whatever `cmd_i` and `target_i` are.
- R3: With `step_i` high and `cmd_i` = 0 (sequential), the program counter becomes its current value plus one.
- R4: Incrementing from address 511 gives address 0.
- R5: With `step_i` high and `cmd_i` = 1 (long jump), the program counter loads all 9 bits of `target_i`.
- R6: With `step_i` high and `cmd_i` = 2 (page jump), bits 8:6 of the program counter are kept and bits 5:0 are loaded from `target_i[5:0]`.
- R7: With `step_i` high and `cmd_i` = 3 (call), the program counter loads `target_i`. The top stack entry receives the current address plus one, and the second entry receives the old top entry.
- R8: A call made while both stack entries are in use discards the older saved address.
- R9: With `step_i` high and `cmd_i` = 4 (return), the program counter loads the top stack entry. The top entry receives the second entry, and the second entry keeps its value.
- R10: A call made from address 511 saves the return address 0.
- R11: The codes 5, 6 and 7 on `cmd_i` behave exactly as the sequential code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Instruction-cycle strobe; the address updates only when it is high |
| cmd_i | input | 3 | Transfer command: 0 sequential, 1 long jump, 2 page jump, 3 call, 4 return, 5-7 sequential |
| target_i | input | 9 | Jump or call target address |
| fetch_addr_o | output | 9 | Current program counter, the fetch address |

## Verification
A corrupted program counter shows up on `fetch_addr_o` at the next sample. A corrupted save-stack entry stays hidden until a return pops it, which may be one or two returns later. For that reason the stimulus nests calls two and three deep and then unwinds them completely. An error in the increment or the page-bit handling appears one cycle after the offending command. The wrap case and the call from the last address are driven on purpose, not left to chance.

// File: rtl/paddr_pkg.sv
package paddr_pkg;
    typedef enum logic [2:0] {
        PC_SEQ  = 3'd0,
        PC_LONG = 3'd1,
        PC_PAGE = 3'd2,
        PC_CALL = 3'd3,
        PC_RET  = 3'd4
    } pc_cmd_e;
endpackage

// File: rtl/paddr_next.sv
module paddr_next
    import paddr_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int OFF_W  = 6,
    localparam int ADDR_W = PAGE_W + OFF_W
) (
    input  logic              step_i,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] top_i,
    output logic [ADDR_W-1:0] pc_next_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic              push_o,
    output logic              pop_o
);
    logic [ADDR_W-1:0] incr;

    always_comb begin
        incr       = pc_i + ADDR_W'(1);
        ret_addr_o = incr;
        push_o     = 1'b0;
        pop_o      = 1'b0;
        pc_next_o  = pc_i;
        if (step_i) begin
            case (cmd_i)
                PC_LONG: pc_next_o = target_i;
                PC_PAGE: pc_next_o = {pc_i[ADDR_W-1:OFF_W], target_i[OFF_W-1:0]};
                PC_CALL: begin
                    pc_next_o = target_i;
                    push_o    = 1'b1;
                end
                PC_RET: begin
                    pc_next_o = top_i;
                    pop_o     = 1'b1;
                end
                default: pc_next_o = incr;
            endcase
        end
    end
endmodule

// File: rtl/paddr_save_stack.sv
module paddr_save_stack #(
    parameter int ADDR_W = 9,
    parameter int DEPTH  = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_val_i,
    output logic [ADDR_W-1:0] top_o
);
    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] slot;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push_i) begin
            stk_d.slot[0] = push_val_i;
            for (int i = 1; i < DEPTH; i++) stk_d.slot[i] = stk_q.slot[i-1];
        end else if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) stk_d.slot[i] = stk_q.slot[i+1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) stk_q <= '0;
        else       stk_q <= stk_d;
    end

    assign top_o = stk_q.slot[0];

    // R7: a push lands on top
    a_r7_push_top: assert property (@(posedge clk_i) disable iff (rst_i)
        push_i |=> stk_q.slot[0] == $past(push_val_i));

    // R9: the deepest entry survives a pop
    a_r9_pop_keep_last: assert property (@(posedge clk_i) disable iff (rst_i)
        (pop_i && !push_i) |=> stk_q.slot[DEPTH-1] == $past(stk_q.slot[DEPTH-1]));

    generate
        if (DEPTH > 1) begin : g_deep
            // R7: the old top moves down on a push
            a_r7_push_shift: assert property (@(posedge clk_i) disable iff (rst_i)
                push_i |=> stk_q.slot[1] == $past(stk_q.slot[0]));
            // R9: a pop brings the second entry up
            a_r9_pop_shift: assert property (@(posedge clk_i) disable iff (rst_i)
                (pop_i && !push_i) |=> stk_q.slot[0] == $past(stk_q.slot[1]));
        end
    endgenerate
endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq #(
    parameter int PAGE_W     = 3,
    parameter int OFF_W      = 6,
    parameter int SAVE_DEPTH = 2,
    localparam int ADDR_W    = PAGE_W + OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] fetch_addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_reg_t;

    pc_reg_t           pc_d, pc_q;
    logic [ADDR_W-1:0] pc_next, ret_addr, stack_top;
    logic              push, pop;

    paddr_next #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_next (
        .step_i    (step_i),
        .cmd_i     (cmd_i),
        .pc_i      (pc_q.pc),
        .target_i  (target_i),
        .top_i     (stack_top),
        .pc_next_o (pc_next),
        .ret_addr_o(ret_addr),
        .push_o    (push),
        .pop_o     (pop)
    );

    paddr_save_stack #(.ADDR_W(ADDR_W), .DEPTH(SAVE_DEPTH)) u_stack (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .push_i    (push),
        .pop_i     (pop),
        .push_val_i(ret_addr),
        .top_o     (stack_top)
    );

    always_comb begin
        pc_d    = pc_q;
        pc_d.pc = pc_next;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pc_q <= '0;
        else       pc_q <= pc_d;
    end

    assign fetch_addr_o = pc_q.pc;

    // R1
    a_r1_reset_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> fetch_addr_o == '0);

    // R2
    a_r2_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(fetch_addr_o));

    // R3, R4, R11
    a_r3_seq_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && (cmd_i == 3'd0 || cmd_i > 3'd4)) |=>
        fetch_addr_o == ADDR_W'($past(fetch_addr_o) + ADDR_W'(1)));

    // R5
    a_r5_long: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && cmd_i == 3'd1) |=> fetch_addr_o == $past(target_i));

    // R6
    a_r6_page_kept: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && cmd_i == 3'd2) |=>
        fetch_addr_o[ADDR_W-1:OFF_W] == $past(fetch_addr_o[ADDR_W-1:OFF_W]) &&
        fetch_addr_o[OFF_W-1:0] == $past(target_i[OFF_W-1:0]));

    // R9
    a_r9_return: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && cmd_i == 3'd4) |=> fetch_addr_o == $past(stack_top));
endmodule

// File: tb/sim_prog_addr_seq.sv
`timescale 1ns/1ps
module sim_prog_addr_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [8:0] target = 9'd0;
    logic [8:0] addr;

    int    checks = 0;
    int    fails = 0;
    int    exp_pc = 0;
    int    stk[$] = '{0, 0};
    string tag = "R1";
    bit    valid = 1'b0;

    always #5 clk = ~clk;

    prog_addr_seq u0 (
        .clk_i(clk), .rst_i(rst), .step_i(step),
        .cmd_i(cmd), .target_i(target), .fetch_addr_o(addr)
    );

    task automatic cyc(input logic r, input logic s, input int c, input int t);
        int v;
        @(negedge clk);
        if (valid) begin
            checks++;
            if (addr !== exp_pc[8:0]) begin
                fails++;
                $display("FAIL %s: fetch_addr=%0d expected=%0d", tag, addr, exp_pc);
            end
        end
        rst = r; step = s; cmd = c[2:0]; target = t[8:0];
        valid = 1'b1;
        if (r) begin
            exp_pc = 0; stk = '{0, 0}; tag = "R1";
        end else if (!s) begin
            tag = "R2";
        end else begin
            case (c)
                1: begin exp_pc = t; tag = "R5"; end
                2: begin exp_pc = (exp_pc & 'h1C0) | (t & 'h3F); tag = "R6"; end
                3: begin
                    tag = (exp_pc == 511) ? "R10" : "R7/R8";
                    stk.push_front((exp_pc + 1) % 512);
                    void'(stk.pop_back());
                    exp_pc = t;
                end
                4: begin
                    v = stk[0]; stk.delete(0); stk.push_back(stk[0]);
                    exp_pc = v; tag = "R9";
                end
                default: begin
                    tag = (c > 4) ? "R11" : ((exp_pc == 511) ? "R4" : "R3");
                    exp_pc = (exp_pc + 1) % 512;
                end
            endcase
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: expired, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) cyc(1, 0, 0, 0);                 // R1
        repeat (5) cyc(0, 1, 0, 0);                 // R3
        cyc(0, 0, 1, 300); cyc(0, 0, 3, 77); cyc(0, 0, 4, 0);  // R2 ignored
        cyc(0, 1, 1, 509);                          // R5
        repeat (4) cyc(0, 1, 0, 0);                 // R4 wrap
        cyc(0, 1, 5, 0); cyc(0, 1, 6, 0); cyc(0, 1, 7, 0);     // R11
        cyc(0, 1, 1, 200); cyc(0, 1, 2, 511);       // R6 keeps page 3
        cyc(0, 1, 2, 64);                           // R6 offset 0
        cyc(0, 1, 3, 100); cyc(0, 1, 0, 0);         // R7
        cyc(0, 1, 3, 400); cyc(0, 1, 3, 20);        // R8 third level
        cyc(0, 0, 4, 0);                            // R2 hold
        repeat (3) cyc(0, 1, 4, 0);                 // R9
        cyc(0, 1, 1, 511); cyc(0, 1, 3, 33);        // R10
        cyc(0, 1, 4, 0);
        cyc(0, 1, 3, 250); cyc(1, 1, 1, 9);         // R1 mid-run
        cyc(0, 1, 4, 0);
        for (int i = 0; i < 3000; i++)
            cyc(0, ($urandom % 4) != 0, $urandom % 8, $urandom % 512);
        cyc(0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule